// File: doc/BRIEF.md
# Distributed Arithmetic FIR Filter with Split Pair Tables

This block is a constant-coefficient FIR filter that uses no multipliers. It forms the inner product of the tap delay line and the coefficient set by distributed arithmetic. The filter works on one bit position per clock cycle, starting with the LSB. In each cycle it takes that bit from every tap sample and uses the bits as lookup addresses into small tables of precomputed coefficient sums. The results are summed across tap groups and then shift-accumulated into a full-precision result.

Each group of four taps uses two 2-input tables instead of one 16-entry table. Each pair table holds four entries (0, h_a, h_b, h_a+h_b), and a multiplexer picks the entry using two address bits. The two pair outputs of a group are added. A summing stage then combines all group results. In the sign-bit cycle the weighted partial sum is subtracted, so that two's-complement samples give exact results.

The controller has two states. In `ST_IDLE`, a high `in_valid` accepts a sample: the delay line shifts, the accumulator clears and the state moves to `ST_RUN`. `ST_RUN` steps the bit index from 0 to DW-1. At index DW-1, which is the sign cycle, it returns to `ST_IDLE`, and `out_done` pulses in the following cycle. Because the controller is back in `ST_IDLE` during that pulse cycle, a new sample can be accepted in the same cycle as the pulse.

Top module: `da_fir`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_done` is 0 and `out_result` is 0. Reset also clears every tap of the delay line to zero.
- R2: A sample is accepted on a rising edge where `in_valid` is 1 and the filter is idle. `out_done` then goes to 1 for exactly one cycle, starting after the DW-th following edge.
- R3: The value of `out_result` at each `out_done` pulse is the sum over i of h_i * x[n-i], in two's complement. Here x[n] is the newest accepted sample at tap 0, and h_i is the signed value in `COEFS[i*CW +: CW]`. The default coefficients h0..h7 are 3, -5, 17, 127, -128, 64, -1, 9.
- R4: Samples are signed with width DW. The sign-bit weight is subtracted, and the result is exact when every sample is -128 and when the samples reach +127. The coefficient -128 is among the coefficients exercised.
- R5: If `in_valid` is 1 while a computation is in progress, it is ignored. The delay line does not shift, the sample is not used, and the timing of `out_done` does not change.
- R6: `out_result` changes only on the edge that raises `out_done`, and keeps its value between pulses.
- R7: If `in_valid` is held at 1, a new sample is accepted every DW+1 cycles, in the same cycle as each `out_done` pulse.
- R8: Each group of four taps is looked up through two 4-entry pair tables whose outputs are added. With an impulse of 1 followed by zeros, the successive results are h0, h1, … in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_sample | input | DW | Signed input sample |
| out_done | output | 1 | One-cycle pulse when a result is ready |
| out_result | output | RW | Signed full-precision filter result |

## Verification
The bench drives samples at -128 and +127. If the sign-bit cycle added instead of subtracting, or if the accumulator were too narrow, the results would be wrong by large multiples of 2^(DW-1).

An impulse response makes the result sequence equal the coefficient list. A swapped pair-table entry or a wrong group order would show up as reordered or mixed coefficients.

In one phase `in_valid` is held high while the sample value changes every cycle. A design that accepted a sample while busy would shift the delay line too early, and would put later results out of step or give wrong values. A design that refused a sample in the pulse cycle would lose one cycle per sample and would miss the expected done cycles.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/da_pair_lut.sv
module da_pair_lut #(
    parameter int CW = 8,
    parameter logic [CW-1:0] H_A = '0,
    parameter logic [CW-1:0] H_B = '0
) (
    input  logic [1:0]    addr,
    output logic [CW:0]   entry
);
    localparam logic signed [CW:0] EA = {H_A[CW-1], H_A};
    localparam logic signed [CW:0] EB = {H_B[CW-1], H_B};

    always_comb begin
        unique case (addr)
            2'b00:   entry = '0;
            2'b01:   entry = EA;
            2'b10:   entry = EB;
            default: entry = EA + EB;
        endcase
    end
endmodule

// File: rtl/da_group.sv
module da_group #(
    parameter int CW = 8,
    parameter logic [4*CW-1:0] HG = '0,
    localparam int GW = CW + 2
) (
    input  logic [3:0]    addr,
    output logic [GW-1:0] gsum
);
    logic [CW:0] lo_e;
    logic [CW:0] hi_e;

    da_pair_lut #(.CW(CW), .H_A(HG[0*CW +: CW]), .H_B(HG[1*CW +: CW])) u_lo (
        .addr (addr[1:0]),
        .entry(lo_e)
    );

    da_pair_lut #(.CW(CW), .H_A(HG[2*CW +: CW]), .H_B(HG[3*CW +: CW])) u_hi (
        .addr (addr[3:2]),
        .entry(hi_e)
    );

    assign gsum = {lo_e[CW], lo_e} + {hi_e[CW], hi_e};
endmodule

// File: rtl/da_sum.sv
module da_sum #(
    parameter int NG = 2,
    parameter int GW = 10,
    parameter int RW = 19
) (
    input  logic [NG*GW-1:0] gin,
    output logic [RW-1:0]    total
);
    always_comb begin
        total = '0;
        for (int g = 0; g < NG; g++) begin
            total = total + {{(RW-GW){gin[g*GW+GW-1]}}, gin[g*GW +: GW]};
        end
    end
endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
    import da_fir_pkg::*;
#(
    parameter int DW = 8,
    localparam int BIW = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             load,
    output logic             step,
    output logic             last,
    output logic             done,
    output logic [BIW-1:0]   bidx,
    output ctl_state_t       state
);
    localparam logic [BIW-1:0] SIGN_IDX = BIW'(DW - 1);

    ctl_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            bidx  <= '0;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= last;
            if (load)      bidx <= '0;
            else if (step) bidx <= bidx + 1'b1;
        end
    end

    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        last     = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    load     = 1'b1;
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (bidx == SIGN_IDX) begin
                    last     = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/da_fir.sv
module da_fir
    import da_fir_pkg::*;
#(
    parameter int NTAPS = 8,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter logic [NTAPS*CW-1:0] COEFS = {8'h09, 8'hFF, 8'h40, 8'h80,
                                             8'h7F, 8'h11, 8'hFB, 8'h03},
    parameter int RW    = DW + CW + $clog2(NTAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    output logic          out_done,
    output logic [RW-1:0] out_result
);
    localparam int NG  = NTAPS / 4;
    localparam int GW  = CW + 2;
    localparam int BIW = $clog2(DW);

    logic              load;
    logic              step;
    logic              last;
    logic [BIW-1:0]    bit_idx;
    ctl_state_t        ctl_state;

    logic [DW-1:0]     taps [NTAPS];
    logic [NTAPS-1:0]  bitvec;
    logic [NG*GW-1:0]  grp_flat;
    logic [RW-1:0]     partial;
    logic signed [RW-1:0] shifted;
    logic signed [RW-1:0] acc;
    logic signed [RW-1:0] acc_nx;

    da_ctrl #(.DW(DW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .load    (load),
        .step    (step),
        .last    (last),
        .done    (out_done),
        .bidx    (bit_idx),
        .state   (ctl_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
        end else if (load) begin
            taps[0] <= in_sample;
            for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
        end
    end

    always_comb begin
        for (int i = 0; i < NTAPS; i++) bitvec[i] = taps[i][bit_idx];
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        da_group #(.CW(CW), .HG(COEFS[g*4*CW +: 4*CW])) u_grp (
            .addr(bitvec[g*4 +: 4]),
            .gsum(grp_flat[g*GW +: GW])
        );
    end

    da_sum #(.NG(NG), .GW(GW), .RW(RW)) u_sum (
        .gin  (grp_flat),
        .total(partial)
    );

    assign shifted = $signed(partial) <<< bit_idx;
    assign acc_nx  = last ? (acc - shifted) : (acc + shifted);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            out_result <= '0;
        end else begin
            if (load)      acc <= '0;
            else if (step) acc <= acc_nx;
            if (last)      out_result <= acc_nx;
        end
    end
endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk
    import da_fir_pkg::*;
#(
    parameter int DW  = 8,
    parameter int RW  = 19,
    parameter int BIW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           done,
    input  logic [RW-1:0]  result,
    input  ctl_state_t     state,
    input  logic [BIW-1:0] bidx
);
    localparam logic [BIW-1:0] SIGN_IDX = BIW'(DW - 1);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && in_valid) |=> (state == ST_RUN && bidx == '0));

    // R2
    sign_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && bidx == SIGN_IDX) |=> (done && state == ST_IDLE));

    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && bidx != SIGN_IDX) |=>
            (state == ST_RUN && bidx == BIW'($past(bidx) + 1'b1)));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> state == ST_IDLE);
endmodule

bind da_fir da_fir_chk #(.DW(DW), .RW(RW), .BIW($clog2(DW))) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .done    (out_done),
    .result  (out_result),
    .state   (ctl_state),
    .bidx    (bit_idx)
);

// File: tb/da_fir_tb.sv
`timescale 1ns/1ps
module da_fir_tb;
    localparam int NT = 8;
    localparam int DW = 8;
    localparam int RW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          out_done;
    logic [RW-1:0] out_result;

    int coef [NT] = '{3, -5, 17, 127, -128, 64, -1, 9};

    int hist [NT];
    int cnt = 0;
    bit exp_done = 1'b0;
    int exp_y = 0;
    bit took = 1'b0;
    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string tag = "R3";
    int lcg = 12345;

    always #2 clk = ~clk;

    da_fir u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_done  (out_done),
        .out_result(out_result)
    );

    function automatic int conv();
        int s = 0;
        for (int i = 0; i < NT; i++) s += hist[i] * coef[i];
        return s;
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        took = 1'b0;
        if (rst) begin
            for (int i = 0; i < NT; i++) hist[i] = 0;
            cnt = 0; exp_done = 1'b0; exp_y = 0;
        end else begin
            exp_done = 1'b0;
            if (cnt == 0 && in_valid) begin
                for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = int'($signed(in_sample));
                cnt = DW;
                took = 1'b1;
            end else if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    exp_done = 1'b1;
                    exp_y = conv();
                end
            end
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            int act;
            act = int'($signed(out_result));
            checks++;
            if (out_done !== exp_done) begin
                failures++;
                $display("FAIL R2 done actual=%0b expected=%0b", out_done, exp_done);
            end
            checks++;
            if (act != exp_y) begin
                failures++;
                if (exp_done)
                    $display("FAIL %s result actual=%0d expected=%0d", tag, act, exp_y);
                else
                    $display("FAIL R6 held result actual=%0d expected=%0d", act, exp_y);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic push(input int s);
        in_valid  = 1'b1;
        in_sample = DW'(s);
        do @(negedge clk); while (!took);
        in_valid  = 1'b0;
    endtask

    task automatic drain();
        repeat (DW + 3) @(negedge clk);
    endtask

    function automatic int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 16) & 255;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (out_done !== 1'b0 || out_result !== '0) begin
            failures++;
            $display("FAIL R1 reset actual=%0b/%0d expected=0/0", out_done, out_result);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_done !== 1'b0 || out_result !== '0) begin
            failures++;
            $display("FAIL R1 after reset actual=%0b/%0d expected=0/0", out_done, out_result);
        end

        // R8 impulse response walks the coefficients in order
        tag = "R8";
        push(1);
        for (int k = 0; k < NT + 1; k++) push(0);
        drain();

        // R4 most negative and most positive samples
        tag = "R4";
        for (int k = 0; k < NT + 1; k++) push(-128);
        for (int k = 0; k < NT + 1; k++) push(127);
        for (int k = 0; k < NT; k++) push((k % 2) ? -128 : 127);
        drain();

        // R3 varied samples
        tag = "R3";
        for (int k = 0; k < 40; k++) push(next_rand());
        drain();

        // R5 / R7 valid held high with changing data
        tag = "R7";
        in_valid = 1'b1;
        for (int k = 0; k < 120; k++) begin
            in_sample = DW'(next_rand());
            @(negedge clk);
        end
        in_valid = 1'b0;
        drain();

        // R5 brief valid pulses during busy cycles
        tag = "R5";
        for (int k = 0; k < 10; k++) begin
            push(next_rand());
            in_valid = 1'b1; in_sample = 8'h80;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (DW) @(negedge clk);
        end
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule